// File: doc/BRIEF.md
# Tag Session Sequencer With 4-Bit Reply Check

This block runs one complete read session against a contactless memory tag. It directs an external bit transmitter, an external bit receiver and an external keystream generator through strobes. On its own it handles carrier timing, the wake-up handshake, detection of the tag's memory size and the sequence of single-byte reads. Time is measured in ticks of a slow timer, and each tick arrives as a one-cycle enable pulse.

A session begins with a start pulse, a first byte address and a byte count. The sequencer powers the tag and performs the handshake. It then decodes the tag's size reply and power-cycles the tag. After that it repeats the handshake and reads the bytes one at a time. Every reply holds a data byte and a 4-bit check code. The block recomputes that code bit by bit over the command it sent and the returned byte. A byte that passes the check goes out on a valid strobe. A byte that fails ends the session with an error. The session also ends with an error when the size reply is not recognised.

Top module: `tag_session_seq`

## Requirements
- R1: On start, the carrier turns on and remains on for at least CHARGE_TICKS ticks. The first frame then goes out: the 7-bit value IV (default 0x55), with `ks_init_o` pulsing in the same cycle and `ks_seed_o` = 0.
- R2: When that first frame completes, `ks_init_o` pulses with `ks_seed_o` = IV, and in the same cycle `rx_start_o` requests a 6-bit reply.
- R3: After the 6-bit reply arrives, exactly one `ks_step_o` pulse follows. At least GAP_TICKS ticks after the reply ended, the 6-bit value ACK (default 0x19) is sent.
- R4: A first-pass reply of 0x1D sets `size_o` = 1 (256 bytes, 9-bit commands). A reply of 0x3D sets `size_o` = 2 (1024 bytes, 11-bit commands). Any other reply sets `err_o`, keeps `size_o` = 0 and performs no reads. `size_o` never takes the value 3.
- R5: After a recognised size, the carrier stays off for at least OFF_TICKS ticks, and the handshake of R1 to R3 then runs a second time. The reply to this second handshake is not decoded.
- R6: Each read is preceded by exactly four `ks_step_o` pulses counted from the previous frame end. At least GAP_TICKS ticks after that frame end, the command (address << 1) | 1 is sent with `tx_bits_o` equal to the command width. A 12-bit reply is then requested.
- R7: The reply carries the data byte in bits 7:0 and the check code in bits 11:8. The check starts from 0x5. Each input bit, least significant bit first, is handled as follows: the register shifts right, and the register is XORed with 0xC when its old bit 0 differs from the input bit. The input bits are the command bits (width of the command) followed by the 8 data bits. On a match, `byte_valid_o` pulses with `byte_o` and `byte_addr_o`.
- R8: On a mismatch, `err_o` is set, the byte is not delivered and no further read is made.
- R9: The number of bytes read is min(count, size - offset). The number is 0 when offset >= size.
- R10: Every session ends with the carrier off for at least OFF_TICKS ticks, followed by a one-cycle `done_o` pulse while the carrier is off.
- R11: Out of reset the carrier is off, all strobes are low, `size_o` = 0 and `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only while idle |
| offset_i | input | 10 | First byte address |
| count_i | input | 11 | Requested byte count |
| tick_i | input | 1 | Timer tick enable |
| tx_done_i | input | 1 | Transmitter finished the current frame |
| rx_done_i | input | 1 | Receiver finished; `rx_data_i` is valid |
| rx_data_i | input | 12 | Decrypted received bits, first bit in bit 0 |
| carrier_o | output | 1 | Carrier enable |
| tx_start_o | output | 1 | Start a transmit frame |
| tx_data_o | output | 11 | Frame bits, first bit in bit 0 |
| tx_bits_o | output | 4 | Frame length in bits |
| rx_start_o | output | 1 | Start a receive frame |
| rx_bits_o | output | 4 | Reply length in bits |
| ks_init_o | output | 1 | Reseed the keystream generator |
| ks_seed_o | output | 7 | Seed value |
| ks_step_o | output | 1 | Advance the keystream by one step |
| byte_valid_o | output | 1 | Checked byte available |
| byte_o | output | 8 | Data byte |
| byte_addr_o | output | 10 | Address of the byte |
| size_o | output | 2 | 0 unknown, 1 = 256 bytes, 2 = 1024 bytes |
| err_o | output | 1 | Session ended with an error; held until next start |
| done_o | output | 1 | Session finished pulse |

## Verification
The bench builds the block with CHARGE_TICKS = 8, OFF_TICKS = 12 and GAP_TICKS = 20, and pulses a tick every second cycle. These short timings leave room for a full read of every address of the small card, which puts all 256 command values and a varied set of data bytes through the check code. They also leave room for reads in the top window of the large card, including address 1023. Further sessions hit the length clamp on both sides, a zero count, an offset past the end, an unknown size reply, and a corrupted check code on the first read and on a later one.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int ADDR_W = 10;
  localparam int LEN_W  = 11;
  localparam int CMD_W  = 11;
  localparam int RPL_W  = 12;
  localparam int CRC_W  = 4;
  localparam int FEED_W = CMD_W + 8;
  localparam int NB_W   = 4;
  localparam int FC_W   = 5;

  localparam logic [CRC_W-1:0] CRC_POLY = 4'hC;
  localparam logic [CRC_W-1:0] CRC_INIT = 4'h5;

  localparam logic [5:0]       ID_SMALL    = 6'h1D;
  localparam logic [5:0]       ID_LARGE    = 6'h3D;
  localparam logic [NB_W-1:0]  CMDW_SMALL  = 4'd9;
  localparam logic [NB_W-1:0]  CMDW_LARGE  = 4'd11;
  localparam logic [LEN_W-1:0] BYTES_SMALL = 11'd256;
  localparam logic [LEN_W-1:0] BYTES_LARGE = 11'd1024;

  typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_SMALL = 2'd1, SZ_LARGE = 2'd2} size_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHARGE, S_TX_IV, S_RX_ID, S_KS, S_WAIT_ACK, S_TX_ACK,
    S_OFF, S_WAIT_CMD, S_TX_CMD, S_RX_DAT, S_CRC, S_CHECK
  } st_e;

  typedef struct packed {
    st_e               st;
    logic              carrier;
    logic              txs;
    logic [CMD_W-1:0]  txd;
    logic [NB_W-1:0]   txb;
    logic              rxs;
    logic [NB_W-1:0]   rxb;
    logic              ksi;
    logic [6:0]        seed;
    logic [2:0]        ksl;
    logic              rd;
    logic              pass2;
    logic              fin;
    logic [NB_W-1:0]   cmdw;
    size_e             size;
    logic              err;
    logic              done;
    logic [ADDR_W-1:0] off;
    logic [LEN_W-1:0]  req;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  left;
    logic [RPL_W-1:0]  reply;
    logic [FEED_W-1:0] feed;
    logic [FC_W-1:0]   fcnt;
    logic              bv;
    logic [7:0]        byte_d;
    logic [ADDR_W-1:0] baddr;
  } seq_regs_t;
endpackage

// File: rtl/tss_crc4.sv
module tss_crc4
  import tss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_n;
  logic             fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_n = crc_q;
    if (clr) begin
      crc_n = CRC_INIT;
    end else if (en) begin
      crc_n = (crc_q >> 1) ^ (fb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_n;
  end

  assign crc_o = crc_q;

  // R7: a new check never starts while bits are still being shifted in
  a_r7_no_load_during_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && en));
endmodule

// File: rtl/tss_tick_cnt.sv
module tss_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                        cnt_n = '0;
    else if (tick && (cnt_q != '1)) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  // R6: elapsed time since a frame end only grows until the next clear
  a_r6_time_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/tag_session_seq.sv
module tag_session_seq
  import tss_pkg::*;
#(
  parameter int         CHARGE_TICKS = 1500,
  parameter int         OFF_TICKS    = 15000,
  parameter int         GAP_TICKS    = 387,
  parameter logic [6:0] IV           = 7'h55,
  parameter logic [5:0] ACK          = 6'h19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic [RPL_W-1:0]  rx_data_i,
  output logic              carrier_o,
  output logic              tx_start_o,
  output logic [CMD_W-1:0]  tx_data_o,
  output logic [NB_W-1:0]   tx_bits_o,
  output logic              rx_start_o,
  output logic [NB_W-1:0]   rx_bits_o,
  output logic              ks_init_o,
  output logic [6:0]        ks_seed_o,
  output logic              ks_step_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [1:0]        size_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int MAX_A = (CHARGE_TICKS > OFF_TICKS) ? CHARGE_TICKS : OFF_TICKS;
  localparam int MAX_T = (MAX_A > GAP_TICKS) ? MAX_A : GAP_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] T_CHARGE = TW'(CHARGE_TICKS);
  localparam logic [TW-1:0] T_OFF    = TW'(OFF_TICKS);
  localparam logic [TW-1:0] T_GAP    = TW'(GAP_TICKS);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  seq_regs_t        r_q, r_n;
  logic [TW-1:0]    tcnt;
  logic             tclr;
  logic             crc_clr, crc_en;
  logic [CRC_W-1:0] crc;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [ADDR_W-1:0] off,
                                                 input logic [LEN_W-1:0]  req,
                                                 input logic [LEN_W-1:0]  sz);
    logic [LEN_W-1:0] room;
    room = sz - {1'b0, off};
    if ({1'b0, off} >= sz) return '0;
    return (req > room) ? room : req;
  endfunction

  always_comb begin
    r_n      = r_q;
    r_n.txs  = 1'b0;
    r_n.rxs  = 1'b0;
    r_n.ksi  = 1'b0;
    r_n.bv   = 1'b0;
    r_n.done = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    unique case (r_q.st)
      S_IDLE: if (start_i) begin
        r_n.off = offset_i;  r_n.req  = count_i;  r_n.err = 1'b0;
        r_n.size = SZ_NONE;  r_n.pass2 = 1'b0;    r_n.rd = 1'b0;
        r_n.fin = 1'b0;      r_n.carrier = 1'b1;  r_n.st = S_CHARGE;
      end
      S_CHARGE: if (tcnt >= T_CHARGE) begin
        r_n.ksi = 1'b1; r_n.seed = '0;
        r_n.txs = 1'b1; r_n.txd = CMD_W'(IV); r_n.txb = 4'd7;
        r_n.st  = S_TX_IV;
      end
      S_TX_IV: if (tx_done_i) begin
        r_n.ksi = 1'b1; r_n.seed = IV;
        r_n.rxs = 1'b1; r_n.rxb = 4'd6;
        r_n.st  = S_RX_ID;
      end
      S_RX_ID: if (rx_done_i) begin
        r_n.reply = rx_data_i; r_n.ksl = 3'd1; r_n.st = S_KS;
      end
      S_KS: begin
        r_n.ksl = r_q.ksl - 3'd1;
        if (r_q.ksl == 3'd1) r_n.st = r_q.rd ? S_WAIT_CMD : S_WAIT_ACK;
      end
      S_WAIT_ACK: if (tcnt >= T_GAP) begin
        r_n.txs = 1'b1; r_n.txd = CMD_W'(ACK); r_n.txb = 4'd6;
        r_n.st  = S_TX_ACK;
      end
      S_TX_ACK: if (tx_done_i) begin
        if (r_q.pass2) begin
          if (r_q.left == '0) begin
            r_n.fin = 1'b1; r_n.carrier = 1'b0; r_n.st = S_OFF;
          end else begin
            r_n.rd = 1'b1; r_n.ksl = 3'd4; r_n.st = S_KS;
          end
        end else begin
          r_n.carrier = 1'b0;
          r_n.st      = S_OFF;
          r_n.addr    = r_q.off;
          if (r_q.reply[5:0] == ID_SMALL) begin
            r_n.size = SZ_SMALL; r_n.cmdw = CMDW_SMALL;
            r_n.left = clamp_len(r_q.off, r_q.req, BYTES_SMALL);
          end else if (r_q.reply[5:0] == ID_LARGE) begin
            r_n.size = SZ_LARGE; r_n.cmdw = CMDW_LARGE;
            r_n.left = clamp_len(r_q.off, r_q.req, BYTES_LARGE);
          end else begin
            r_n.err = 1'b1; r_n.fin = 1'b1;
          end
        end
      end
      S_OFF: if (tcnt >= T_OFF) begin
        if (r_q.fin) begin
          r_n.done = 1'b1; r_n.st = S_IDLE;
        end else begin
          r_n.carrier = 1'b1; r_n.pass2 = 1'b1; r_n.st = S_CHARGE;
        end
      end
      S_WAIT_CMD: if (tcnt >= T_GAP) begin
        r_n.txs = 1'b1; r_n.txd = {r_q.addr, 1'b1}; r_n.txb = r_q.cmdw;
        r_n.st  = S_TX_CMD;
      end
      S_TX_CMD: if (tx_done_i) begin
        r_n.rxs = 1'b1; r_n.rxb = 4'd12; r_n.st = S_RX_DAT;
      end
      S_RX_DAT: if (rx_done_i) begin
        crc_clr   = 1'b1;
        r_n.reply = rx_data_i;
        r_n.feed  = {8'b0, r_q.txd} | ({11'b0, rx_data_i[7:0]} << r_q.cmdw);
        r_n.fcnt  = {1'b0, r_q.cmdw} + 5'd8;
        r_n.st    = S_CRC;
      end
      S_CRC: begin
        crc_en   = 1'b1;
        r_n.feed = r_q.feed >> 1;
        r_n.fcnt = r_q.fcnt - 5'd1;
        if (r_q.fcnt == 5'd1) r_n.st = S_CHECK;
      end
      S_CHECK: begin
        if (crc == r_q.reply[11:8]) begin
          r_n.bv = 1'b1; r_n.byte_d = r_q.reply[7:0]; r_n.baddr = r_q.addr;
          r_n.addr = r_q.addr + 1'b1;
          r_n.left = r_q.left - 1'b1;
          if (r_q.left == 11'd1) begin
            r_n.fin = 1'b1; r_n.carrier = 1'b0; r_n.st = S_OFF;
          end else begin
            r_n.ksl = 3'd4; r_n.st = S_KS;
          end
        end else begin
          r_n.err = 1'b1; r_n.fin = 1'b1; r_n.carrier = 1'b0; r_n.st = S_OFF;
        end
      end
      default: r_n.st = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) r_q <= '0;
    else        r_q <= r_n;
  end

  assign tclr = tx_done_i | rx_done_i |
                ((r_n.st != r_q.st) && ((r_n.st == S_CHARGE) || (r_n.st == S_OFF)));

  tss_tick_cnt #(.W(TW)) u_time (
    .clk(clk), .rst_n(rst_l), .clr(tclr), .tick(tick_i), .cnt_o(tcnt)
  );

  tss_crc4 u_crc (
    .clk(clk), .rst_n(rst_l), .clr(crc_clr), .en(crc_en), .din(r_q.feed[0]), .crc_o(crc)
  );

  assign carrier_o    = r_q.carrier;
  assign tx_start_o   = r_q.txs;
  assign tx_data_o    = r_q.txd;
  assign tx_bits_o    = r_q.txb;
  assign rx_start_o   = r_q.rxs;
  assign rx_bits_o    = r_q.rxb;
  assign ks_init_o    = r_q.ksi;
  assign ks_seed_o    = r_q.seed;
  assign ks_step_o    = (r_q.st == S_KS);
  assign byte_valid_o = r_q.bv;
  assign byte_o       = r_q.byte_d;
  assign byte_addr_o  = r_q.baddr;
  assign size_o       = r_q.size;
  assign err_o        = r_q.err;
  assign done_o       = r_q.done;

  // R1: frames and keystream steps happen only while the tag is powered
  a_r1_activity_needs_carrier: assert property (@(posedge clk) disable iff (!rst_l)
    (tx_start_o || rx_start_o || ks_step_o) |-> carrier_o);
  // R2: a reseed always coincides with the start of a frame
  a_r2_seed_with_frame: assert property (@(posedge clk) disable iff (!rst_l)
    ks_init_o |-> (tx_start_o || rx_start_o));
  // R4: the size code stays within its three legal values
  a_r4_size_code_legal: assert property (@(posedge clk) disable iff (!rst_l)
    size_o != 2'd3);
  // R8: a delivered byte never coexists with an error or an unknown size
  a_r8_valid_clean: assert property (@(posedge clk) disable iff (!rst_l)
    byte_valid_o |-> (!err_o && (size_o != 2'd0)));
  // R10: the session ends with the tag unpowered, and done is a single pulse
  a_r10_done_unpowered: assert property (@(posedge clk) disable iff (!rst_l)
    done_o |-> (!carrier_o && !$past(done_o)));
endmodule

// File: tb/tb_tag_session_seq.sv
module tb_tag_session_seq;
  localparam int CH = 8, OFFT = 12, GAP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  offset_i = '0;
  logic [10:0] count_i = '0;
  logic        tick_i = 1'b0;
  logic        tx_done_i = 1'b0, rx_done_i = 1'b0;
  logic [11:0] rx_data_i = '0;
  logic        carrier_o, tx_start_o, rx_start_o, ks_init_o, ks_step_o;
  logic [10:0] tx_data_o;
  logic [3:0]  tx_bits_o, rx_bits_o;
  logic [6:0]  ks_seed_o;
  logic        byte_valid_o, err_o, done_o;
  logic [7:0]  byte_o;
  logic [9:0]  byte_addr_o;
  logic [1:0]  size_o;

  always #2 clk = ~clk;

  tag_session_seq #(.CHARGE_TICKS(CH), .OFF_TICKS(OFFT), .GAP_TICKS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i), .count_i(count_i),
    .tick_i(tick_i), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i), .rx_data_i(rx_data_i),
    .carrier_o(carrier_o), .tx_start_o(tx_start_o), .tx_data_o(tx_data_o),
    .tx_bits_o(tx_bits_o), .rx_start_o(rx_start_o), .rx_bits_o(rx_bits_o),
    .ks_init_o(ks_init_o), .ks_seed_o(ks_seed_o), .ks_step_o(ks_step_o),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .byte_addr_o(byte_addr_o),
    .size_o(size_o), .err_o(err_o), .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic [5:0] id_reply;
  int bad_addr, salt, cmdw_exp, exp_addr, byte_cnt, iv_cnt;
  int on_ticks = 0, off_ticks = 0, gap_ticks = 0, ks_cnt = 0;
  bit carrier_prev = 1'b0;
  int tx_cd = 0, rx_cd = 0;
  logic [10:0] last_cmd = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] crc_ref(input logic [18:0] v, input int n);
    logic [3:0] s;
    logic fb;
    s = 4'h5;
    for (int i = 0; i < n; i++) begin
      fb = s[0] ^ v[i];
      s = s >> 1;
      if (fb) s = s ^ 4'hC;
    end
    return s;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) ^ (a >> 2) ^ salt);
  endfunction

  // tag-side model: transmitter, receiver, tick source
  always @(posedge clk) begin
    int a;
    logic [7:0] d;
    logic [3:0] c;
    #1;
    tick_i = ~tick_i;
    tx_done_i = 1'b0;
    rx_done_i = 1'b0;
    if (tx_cd > 0) begin tx_cd--; if (tx_cd == 0) tx_done_i = 1'b1; end
    if (rx_cd > 0) begin rx_cd--; if (rx_cd == 0) rx_done_i = 1'b1; end
    if (tx_start_o) begin tx_cd = 3; last_cmd = tx_data_o; end
    if (rx_start_o) begin
      rx_cd = 4;
      if (rx_bits_o == 4'd6) rx_data_i = {6'b0, id_reply};
      else begin
        a = int'(last_cmd >> 1);
        d = pat(a);
        c = crc_ref(19'(last_cmd) | (19'(d) << cmdw_exp), cmdw_exp + 8);
        if (a == bad_addr) c = c ^ 4'h3;
        rx_data_i = {c, d};
      end
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (carrier_o) begin
      if (!carrier_prev) begin
        if (iv_cnt > 0) chk(off_ticks >= OFFT, "R5", "carrier off ticks", off_ticks, OFFT);
        on_ticks = 0;
      end
      if (tick_i) on_ticks++;
    end else begin
      if (carrier_prev) off_ticks = 0;
      if (tick_i) off_ticks++;
    end
    if (tx_done_i || rx_done_i) begin gap_ticks = 0; ks_cnt = 0; end
    else if (tick_i) gap_ticks++;
    if (ks_step_o) ks_cnt++;
    if (tx_start_o) begin
      if (tx_bits_o == 4'd7) begin
        iv_cnt++;
        chk(tx_data_o == 11'h55, "R1", "IV value", tx_data_o, 'h55);
        chk(ks_init_o && ks_seed_o == 7'd0, "R1", "zero seed with IV", ks_seed_o, 0);
        chk(on_ticks >= CH, "R1", "charge ticks", on_ticks, CH);
      end else if (tx_bits_o == 4'd6) begin
        chk(tx_data_o == 11'h19, "R3", "ack value", tx_data_o, 'h19);
        chk(ks_cnt == 1, "R3", "steps before ack", ks_cnt, 1);
        chk(gap_ticks >= GAP, "R3", "gap before ack", gap_ticks, GAP);
      end else begin
        chk(tx_bits_o == 4'(cmdw_exp), "R6", "command width", tx_bits_o, cmdw_exp);
        chk(tx_data_o == 11'((exp_addr << 1) | 1), "R6", "command", tx_data_o, (exp_addr << 1) | 1);
        chk(ks_cnt == 4, "R6", "steps before read", ks_cnt, 4);
        chk(gap_ticks >= GAP, "R6", "gap before read", gap_ticks, GAP);
      end
    end
    if (rx_start_o) begin
      if (rx_bits_o == 4'd6)
        chk(ks_init_o && ks_seed_o == 7'h55, "R2", "reseed with IV", ks_seed_o, 'h55);
      else
        chk(rx_bits_o == 4'd12, "R6", "reply width", rx_bits_o, 12);
    end
    if (byte_valid_o) begin
      chk(byte_addr_o == 10'(exp_addr), "R7", "byte address", byte_addr_o, exp_addr);
      chk(byte_o == pat(exp_addr), "R7", "byte value", byte_o, pat(exp_addr));
      exp_addr++;
      byte_cnt++;
    end
    carrier_prev = carrier_o;
  end

  task automatic session(input int off, input int cnt, input logic [5:0] id, input int bad,
                         input int s, input int exp_sz, input int exp_n, input bit exp_err,
                         input int exp_iv);
    bit seen;
    id_reply = id; bad_addr = bad; salt = s;
    cmdw_exp = (id == 6'h1D) ? 9 : 11;
    exp_addr = off; byte_cnt = 0; iv_cnt = 0;
    @(posedge clk); #1;
    start_i = 1'b1; offset_i = 10'(off); count_i = 11'(cnt);
    @(posedge clk); #1;
    start_i = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 60000 && !seen; k++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    if (!seen) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 session watchdog: actual 0 expected 1");
    end else begin
      chk(size_o == 2'(exp_sz), "R4", "size code", size_o, exp_sz);
      chk(err_o == exp_err, "R8", "error flag", err_o, exp_err);
      chk(byte_cnt == exp_n, "R9", "byte count", byte_cnt, exp_n);
      chk(iv_cnt == exp_iv, "R5", "handshakes", iv_cnt, exp_iv);
      chk(!carrier_o, "R10", "carrier at done", carrier_o, 0);
      chk(off_ticks >= OFFT, "R10", "final off ticks", off_ticks, OFFT);
      @(negedge clk);
      chk(!done_o, "R10", "done single pulse", done_o, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!carrier_o && !tx_start_o && !rx_start_o && !ks_step_o && !byte_valid_o && !done_o,
        "R11", "idle outputs", {carrier_o, tx_start_o, rx_start_o, done_o}, 0);
    chk(size_o == 2'd0 && !err_o, "R11", "size and error", {size_o, err_o}, 0);

    session(0,    4,   6'h2A, -1, 8'h11, 0, 0,   1'b1, 1); // R4 unknown reply
    session(0,    256, 6'h1D, -1, 8'h3C, 1, 256, 1'b0, 2); // R7 full small sweep
    session(250,  20,  6'h1D, -1, 8'h5A, 1, 6,   1'b0, 2); // R9 clamp small
    session(1000, 100, 6'h3D, -1, 8'hC3, 2, 24,  1'b0, 2); // R9 clamp large
    session(5,    0,   6'h3D, -1, 8'h00, 2, 0,   1'b0, 2); // R9 zero count
    session(300,  10,  6'h1D, -1, 8'h00, 1, 0,   1'b0, 2); // R9 offset past end
    session(64,   10,  6'h3D, 66, 8'h96, 2, 2,   1'b1, 2); // R8 late mismatch
    session(17,   5,   6'h1D, 17, 8'h69, 1, 0,   1'b1, 2); // R8 first mismatch
    session(1023, 5,   6'h3D, -1, 8'hF0, 2, 1,   1'b0, 2); // R6 top address

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule